// File: doc/BRIEF.md
# Three-Lane 7:1 Serializer with Clock Lane

The block turns a 21-bit parallel word into three serial data lanes plus a fourth serial lane that carries a copy of the word clock. The word clock `pix_clk` is the reference for the parallel input. A second clock, `bit_clk`, runs at seven times its rate and is frequency locked to it. In silicon a PLL would supply `bit_clk`; here it enters as a port. Each input cycle yields one 7-slot frame on every lane. All three data lanes shift in lockstep, most significant bit first.

The parallel word is captured on either edge of `pix_clk`, chosen at run time by `rise_sel`. A free-running slot counter in the `bit_clk` domain paces the frames. It is re-aimed on every synchronized rising edge of `pix_clk`. A holding register per lane sits between capture and shifting, so a frame always carries exactly one word. The clock lane is high for the first four slots of each frame, which places its rising edge on the first data bit.

The input is a continuous source-synchronous stream with no valid/ready handshake. A word is presented every input cycle, and the block has no means to apply back-pressure. `lane_valid` marks the cycles in which the lanes carry real data. Pulling `run_n` low stops everything at once.

Top module: `ser_tx3`

## Requirements
- R1: Lane L (0..2) serializes `par_word[7L+6 : 7L]`; in frame slot k (0..6) lane L carries `par_word[7L+6-k]`, so bit 7L+6 goes out first and bit 7L last.
- R2: With `rise_sel` = 1 the word is captured on the rising edge of `pix_clk`; with `rise_sel` = 0 it is captured on the falling edge; the select may change while running.
- R3: Every frame lasts exactly seven `bit_clk` cycles: one load cycle, after which the word is shifted through the remaining slots. A frame never mixes bits of two input words.
- R4: While `lane_valid` is high, `lane_clk` follows the slot pattern 1,1,1,1,0,0,0 in every frame, so it stays high for exactly four consecutive `bit_clk` cycles and rises in slot 0.
- R5: While `run_n` is low, `lane_out`, `lane_clk` and `lane_valid` are 0 immediately (asynchronously), and all internal state is cleared.
- R6: After `run_n` rises, all outputs stay 0 and `lane_valid` stays low until two words have been loaded into the lanes. `lane_valid` then goes high and stays high until the next shutdown.
- R7: `pix_clk` passes through a two-stage synchronizer. Slot 0 of a frame starts at the third `bit_clk` rising edge after a `pix_clk` rising edge that falls between `bit_clk` edges. The slot counter otherwise wraps from 6 to 0.
- R8: In steady state a word captured on a rising edge leaves in the frame that starts in the next input cycle. A word captured on the falling edge of input cycle i leaves in the frame that starts in cycle i+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Word clock; reference for `par_word` |
| bit_clk | input | 1 | Slot clock at seven times `pix_clk`, frequency locked |
| rise_sel | input | 1 | 1: capture on rising edge of `pix_clk`; 0: on falling edge |
| run_n | input | 1 | Active-low shutdown; low clears state and silences all outputs |
| par_word | input | 21 | Parallel word, bits 0-6 lane 0, 7-13 lane 1, 14-20 lane 2 |
| lane_out | output | 3 | Serial data lanes, bit L is lane L |
| lane_clk | output | 1 | Serial clock lane, pattern 1111000 per frame |
| lane_valid | output | 1 | High once the lanes carry real data |

## Verification
Two things happen on the same `bit_clk` edge. At the load edge, the shift register takes the holding register's word while the holding register takes a newly captured word. A mistake there shows up as a frame mixing two words or repeating one. The bench provokes this with a fresh word every input cycle, made from random values and walking-one, all-ones, all-zeros and alternating patterns. It drives two different words per input cycle, one stable around each `pix_clk` edge, so the rising and falling capture paths feed different data. Every decoded frame must equal the single word that the capture-edge rule and the latency rule pick out. A shutdown pulled in mid-frame is also checked for an immediate silence and a clean restart.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Default geometry of the serializer
  localparam int DEF_LANES       = 3;  // data lanes
  localparam int DEF_SLOTS       = 7;  // bit slots per input cycle
  localparam int DEF_HIGH_SLOTS  = 4;  // clock-lane slots held high per frame
  localparam int DEF_START_LOADS = 2;  // loads before the lanes are declared valid
endpackage

// File: rtl/ser_capture.sv
// Word-clock domain: captures the parallel word on both edges of pix_clk.
// The edge actually used is chosen downstream by rise_sel.
module ser_capture #(
  parameter int WORD_W = 21
) (
  input  logic              pix_clk,
  input  logic              run_n,
  input  logic [WORD_W-1:0] par_word,
  output logic [WORD_W-1:0] cap_rise,
  output logic [WORD_W-1:0] cap_fall
);

  always_ff @(posedge pix_clk or negedge run_n) begin
    if (!run_n) cap_rise <= '0;
    else        cap_rise <= par_word;
  end

  always_ff @(negedge pix_clk or negedge run_n) begin
    if (!run_n) cap_fall <= '0;
    else        cap_fall <= par_word;
  end

endmodule

// File: rtl/ser_align.sv
// Bit-clock domain control: reset synchronizer, word-clock edge detector,
// slot counter, load strobe and start-up qualification.
module ser_align #(
  parameter int SLOTS       = 7,
  parameter int START_LOADS = 2,
  localparam int SW         = $clog2(SLOTS)
) (
  input  logic          bit_clk,
  input  logic          run_n,
  input  logic          pix_clk,
  output logic          rst_b_n,
  output logic          load,
  output logic [SW-1:0] slot,
  output logic          valid
);

  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
  localparam int            LW   = $clog2(START_LOADS + 1);

  logic [1:0]    rst_sync;
  logic [2:0]    pix_sync;
  logic          edge_det;
  logic          locked;
  logic [LW-1:0] ld_cnt;

  // Asynchronous assert, synchronous release of the bit-clock reset
  always_ff @(posedge bit_clk or negedge run_n) begin
    if (!run_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_b_n = rst_sync[1];

  // Two-stage synchronizer plus one history stage for edge detection
  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n) pix_sync <= '0;
    else          pix_sync <= {pix_sync[1:0], pix_clk};
  end
  assign edge_det = pix_sync[1] & ~pix_sync[2];

  // Slot counter: realigns to 0 on a word-clock edge, else wraps at LAST
  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n) begin
      slot   <= '0;
      locked <= 1'b0;
    end else begin
      if (edge_det)          slot <= '0;
      else if (slot == LAST) slot <= '0;
      else                   slot <= slot + SW'(1);
      if (edge_det) locked <= 1'b1;
    end
  end

  // The edge that moves the counter to slot 0 is the load edge
  assign load = edge_det | (locked & (slot == LAST));

  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n)                                   ld_cnt <= '0;
    else if (load && ld_cnt != LW'(START_LOADS))    ld_cnt <= ld_cnt + LW'(1);
  end
  assign valid = (ld_cnt == LW'(START_LOADS));

  p_slot_range_r7: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    slot <= LAST);

  p_realign_r7: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    edge_det |=> slot == '0);

  p_wrap_r3: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    (slot == LAST) |=> slot == '0);

  p_valid_on_load_r6: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    $rose(valid) |-> $past(load));

  p_valid_sticky_r6: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    valid |=> valid);

endmodule

// File: rtl/ser_lane.sv
// One serial lane: holding register (double buffer) and MSB-first shifter.
module ser_lane #(
  parameter int SLOTS = 7
) (
  input  logic             bit_clk,
  input  logic             rst_b_n,
  input  logic             load,
  input  logic [SLOTS-1:0] word_in,
  output logic             ser_out
);

  logic [SLOTS-1:0] hold;
  logic [SLOTS-1:0] shreg;

  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n) begin
      hold  <= '0;
      shreg <= '0;
    end else if (load) begin
      hold  <= word_in;
      shreg <= hold;
    end else begin
      shreg <= {shreg[SLOTS-2:0], 1'b0};
    end
  end

  assign ser_out = shreg[SLOTS-1];

  p_hold_stable_r3: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    !load |=> $stable(hold));

endmodule

// File: rtl/ser_tx3.sv
// Three-lane 7:1 serializer with a clock lane.
module ser_tx3 import ser_pkg::*; #(
  parameter int LANES       = DEF_LANES,
  parameter int SLOTS       = DEF_SLOTS,
  parameter int HIGH_SLOTS  = DEF_HIGH_SLOTS,
  parameter int START_LOADS = DEF_START_LOADS
) (
  input  logic                   pix_clk,
  input  logic                   bit_clk,
  input  logic                   rise_sel,
  input  logic                   run_n,
  input  logic [LANES*SLOTS-1:0] par_word,
  output logic [LANES-1:0]       lane_out,
  output logic                   lane_clk,
  output logic                   lane_valid
);

  localparam int WORD_W = LANES * SLOTS;
  localparam int SW     = $clog2(SLOTS);

  logic [WORD_W-1:0] cap_rise;
  logic [WORD_W-1:0] cap_fall;
  logic [WORD_W-1:0] word_sel;
  logic              rst_b_n;
  logic              load;
  logic [SW-1:0]     slot;
  logic              valid;
  logic [LANES-1:0]  ser_raw;

  ser_capture #(.WORD_W(WORD_W)) u_cap (
    .pix_clk  (pix_clk),
    .run_n    (run_n),
    .par_word (par_word),
    .cap_rise (cap_rise),
    .cap_fall (cap_fall)
  );

  assign word_sel = rise_sel ? cap_rise : cap_fall;

  ser_align #(.SLOTS(SLOTS), .START_LOADS(START_LOADS)) u_align (
    .bit_clk (bit_clk),
    .run_n   (run_n),
    .pix_clk (pix_clk),
    .rst_b_n (rst_b_n),
    .load    (load),
    .slot    (slot),
    .valid   (valid)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ser_lane #(.SLOTS(SLOTS)) u_lane (
      .bit_clk (bit_clk),
      .rst_b_n (rst_b_n),
      .load    (load),
      .word_in (word_sel[l*SLOTS +: SLOTS]),
      .ser_out (ser_raw[l])
    );
  end

  assign lane_out   = valid ? ser_raw : '0;
  assign lane_clk   = valid & (slot < SW'(HIGH_SLOTS));
  assign lane_valid = valid;

  // Length of each high run of the clock lane
  logic [SW:0] hi_run;
  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n)      hi_run <= '0;
    else if (lane_clk) hi_run <= hi_run + (SW+1)'(1);
    else               hi_run <= '0;
  end

  p_clk_high_len_r4: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    (valid && $fell(lane_clk)) |-> hi_run == (SW+1)'(HIGH_SLOTS));

  always @(negedge bit_clk) begin
    if (!run_n) begin
      p_off_in_shutdown_r5: assert (lane_out == '0 && !lane_clk && !lane_valid);
    end
  end

endmodule

// File: tb/sim_ser_tx3.sv
`timescale 1ns/100ps
module sim_ser_tx3;
  localparam int LANES = 3;
  localparam int SLOTS = 7;
  localparam int W     = LANES * SLOTS;

  logic             bit_clk  = 1'b0;
  logic             pix_clk  = 1'b0;
  logic             rise_sel = 1'b1;
  logic             run_n    = 1'b0;
  logic [W-1:0]     par_word = '0;
  logic [LANES-1:0] lane_out;
  logic             lane_clk;
  logic             lane_valid;

  int checks = 0;
  int fails  = 0;
  int rc     = -1;
  int skip   = 0;
  int frames = 0;
  int dead_bad = 0;
  bit done = 0;
  logic [W-1:0] wa [64];
  logic [W-1:0] wb [64];

  ser_tx3 u0 (
    .pix_clk(pix_clk), .bit_clk(bit_clk), .rise_sel(rise_sel), .run_n(run_n),
    .par_word(par_word), .lane_out(lane_out), .lane_clk(lane_clk),
    .lane_valid(lane_valid)
  );

  always #2.5 bit_clk = ~bit_clk;  // 200 MHz slot clock

  function automatic logic [W-1:0] gen(input int j);
    case (j % 16)
      3:       return '1;
      4:       return '0;
      5:       return W'(32'h0015_5555);
      6:       return W'(1) << (j % W);
      default: return W'($urandom);
    endcase
  endfunction

  // Word clock: high 20 ns, low 15 ns; one word stable around each edge
  initial begin
    void'($urandom(32'd20240611));
    #3.5;
    forever begin
      pix_clk = 1'b1;
      rc++;
      #10 wa[rc & 63] = gen(2 * rc);     par_word = wa[rc & 63];
      #10 pix_clk = 1'b0;
      #7  wb[rc & 63] = gen(2 * rc + 1); par_word = wb[rc & 63];
      #8;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Frame decoder: R1 R2 R3 R4 R8
  int           fslot = 0;
  bit           in_frame = 0;
  logic         prev_clk = 1'b0;
  logic [W-1:0] exp_w, act_w;
  logic [6:0]   act_c;
  always @(negedge bit_clk) begin
    if (!lane_valid) begin
      if (lane_out != '0 || lane_clk) dead_bad++;
      in_frame = 0;
      prev_clk = 1'b0;
    end else begin
      if (lane_clk && !prev_clk) begin
        if (in_frame && skip == 0)
          chk(fslot == SLOTS, "R3", "frame length", 32'(fslot), 32'(SLOTS));
        in_frame = 1;
        fslot = 0;
        exp_w = rise_sel ? wb[(rc - 2) & 63] : wa[(rc - 2) & 63];
        act_w = '0;
        act_c = '0;
      end
      if (in_frame && fslot < SLOTS) begin
        for (int l = 0; l < LANES; l++) act_w[l*SLOTS + SLOTS-1 - fslot] = lane_out[l];
        act_c[SLOTS-1 - fslot] = lane_clk;
        if (fslot == SLOTS - 1) begin
          if (skip > 0) skip--;
          else begin
            frames++;
            chk(act_w == exp_w, rise_sel ? "R1 R2 R8 rise" : "R1 R2 R8 fall",
                "frame word", 32'(act_w), 32'(exp_w));
            chk(act_c == 7'b1111000, "R4", "clock lane pattern",
                32'(act_c), 32'h78);
          end
        end
      end
      if (in_frame) fslot++;
      prev_clk = lane_clk;
    end
  end

  task automatic release_run();
    skip = 2;
    @(posedge pix_clk);
    #25 run_n = 1'b1;
    #55 chk(!lane_valid && lane_out == '0 && !lane_clk, "R6", "quiet after one load",
            {29'd0, lane_valid, lane_clk, |lane_out}, 32'd0);
    #7  chk(lane_valid, "R6", "valid after two loads", 32'(lane_valid), 32'd1);
  endtask

  task automatic shutdown_now();
    @(posedge bit_clk);
    #1.2 run_n = 1'b0;
    #0.5 chk(lane_out == '0 && !lane_clk && !lane_valid, "R5", "immediate silence",
             {29'd0, lane_valid, lane_clk, |lane_out}, 32'd0);
    repeat (3) @(negedge bit_clk);
    chk(lane_out == '0 && !lane_clk && !lane_valid, "R5", "silent while held",
        {29'd0, lane_valid, lane_clk, |lane_out}, 32'd0);
  endtask

  initial begin
    #50;
    chk(lane_out == '0 && !lane_clk && !lane_valid, "R5", "reset state",
        {29'd0, lane_valid, lane_clk, |lane_out}, 32'd0);
    // Rising-edge capture
    release_run();
    #(35 * 40);
    // Frame boundary follows the synchronized word-clock edge
    @(posedge pix_clk);
    #13 chk(!lane_clk, "R7", "slot 6 before third edge", 32'(lane_clk), 32'd0);
    #3  chk(lane_clk, "R7", "slot 0 at third edge", 32'(lane_clk), 32'd1);
    #(35 * 20);
    // Run-time switch to falling-edge capture
    @(posedge pix_clk);
    #5 skip = 3; rise_sel = 1'b0;
    #(35 * 50);
    // Shutdown in mid-stream, restart in falling mode
    shutdown_now();
    #100;
    release_run();
    #(35 * 40);
    // Shutdown, change select while off, restart in rising mode
    shutdown_now();
    rise_sel = 1'b1;
    #60;
    release_run();
    #(35 * 40);
    chk(frames > 100, "R3", "frames decoded", 32'(frames), 32'd100);
    chk(dead_bad == 0, "R6", "outputs quiet while not valid", 32'(dead_bad), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule